// File: doc/BRIEF.md
# Microcoded Next-Address Sequencer

This block steps the control unit of a microcoded 16-bit processor. It holds a 6-bit state number, reads a 35-bit control word for that state from an internal control store, and forms the next state number from the word's sequencing fields. Those fields are a 6-bit jump address, a 2-bit branch-condition selector and a dispatch flag. The selected condition may set one bit of the jump address. When the dispatch flag is set, the opcode replaces the jump address outright.

The branch-enable flag is computed inside the block. In the decode state it is captured from the three condition-code inputs and instruction bits 11..9. The branch state then reads the stored flag. Instruction fetch waits in a memory-wait state until memory reports ready. The load, store and trap flows have their own wait states. The datapath consumes the other 26 bits of the control word. The datapath, the register file and the memory are not part of this block.

Top module: `useq_sequencer`

## Requirements
- R1: A synchronous active-low reset puts the state at 18 and clears the branch-enable flag. `ctrl_o` then shows the word for state 18, whose jump field (bits 31..26) is 33 and whose MAR-load bit (bit 25) is set.
- R2: Fetch states 18 and 19 both go to state 33 on the next rising edge.
- R3: In state 33 the sequencer stays in 33 while `mem_ready` is low and moves to 35 on the edge where it is high. State 35 always goes to 32.
- R4: State 32 dispatches to state {0,0,opcode}, where the opcode is `ir_bits[6:3]` (instruction bits 15..12).
- R5: In state 32 the branch-enable flag is loaded with (ir_bits[2] & N) | (ir_bits[1] & Z) | (ir_bits[0] & P), where `cc_nzp` is {N,Z,P}. The branch state 0 goes to 22 if the stored flag is set and to 18 if it is clear.
- R6: The subroutine-call state 4 goes to 21 when `ir_bits[2]` (instruction bit 11) is 1 and to 20 when it is 0.
- R7: The memory-wait states 28, 29, 25, 16 and 17 hold while `mem_ready` is low. When it is high they advance to 30, 31, 27, 18 and 19 respectively.
- R8: Control word layout: bit 34 is the dispatch flag, bits 33..32 select the condition (00 none, 01 ready into J[1], 10 branch-enable into J[2], 11 instruction bit 11 into J[0]), and bits 31..26 are the jump address. The dispatch flag (bit 34) and the branch-enable load (bit 22) are set only in state 32. The instruction-register load (bit 23) is set only in state 35.
- R9: States 10 and 11 are entered only from state 32 with the reserved opcodes 1010 and 1011. They return to 18.
- R10: The flows run without conditions: load setup 2→29 and 6→25, store setup 3→24→17 and 7→23→16, trap 15→28. The finishing states 1, 5, 8, 9, 12, 13, 14, 20, 21, 22, 27, 30 and 31, and every unused state, go to 18.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_ready | input | 1 | Memory access complete |
| ir_bits | input | 7 | Instruction bits 15..9 |
| cc_nzp | input | 3 | Condition codes {N,Z,P} |
| state_o | output | 6 | Current state number |
| ctrl_o | output | 35 | Control word of the current state |
| ben_o | output | 1 | Stored branch-enable flag |

## Verification
Two things can act in the same cycle: the decode state dispatches on the opcode, and in that same cycle it captures the branch-enable flag that the branch state uses one cycle later. The bench drives branch instructions whose condition-code and instruction-bit mixes give both flag values. Its behavioural model checks the flag and the branch successor on every clock. A second overlap is a memory-wait state seeing `mem_ready` in the cycle it would otherwise loop. The bench drives the ready input with a pseudo-random pattern. This gives both immediate exits and long holds in every wait state, and each one is judged against the model's per-state transition.

// File: rtl/useq_pkg.sv
package useq_pkg;

  localparam int ST_W       = 6;
  localparam int OP_W       = 4;
  localparam int DP_W       = 26;
  localparam int COND_W     = 2;
  localparam int CW_W       = 1 + COND_W + ST_W + DP_W;
  localparam int NUM_STATES = 1 << ST_W;

  // datapath bit positions inside the low DP_W bits
  localparam int DP_LD_MAR    = 25;
  localparam int DP_LD_MDR    = 24;
  localparam int DP_LD_IR     = 23;
  localparam int DP_LD_BEN    = 22;
  localparam int DP_LD_REG    = 21;
  localparam int DP_LD_CC     = 20;
  localparam int DP_LD_PC     = 19;
  localparam int DP_GATE_PC   = 18;
  localparam int DP_GATE_MDR  = 17;
  localparam int DP_GATE_ALU  = 16;
  localparam int DP_GATE_ADDR = 15;
  localparam int DP_GATE_SHF  = 14;
  localparam int DP_PCSEL     = 12;  // 2 bits
  localparam int DP_DRSEL     = 11;
  localparam int DP_SR1SEL    = 10;
  localparam int DP_BASESEL   = 9;
  localparam int DP_OFFSEL    = 7;   // 2 bits
  localparam int DP_ADDRSEL   = 6;
  localparam int DP_ALUOP     = 4;   // 2 bits
  localparam int DP_MEM_EN    = 3;
  localparam int DP_WRITE     = 2;
  localparam int DP_WORD      = 1;
  localparam int DP_SHL1      = 0;

  typedef enum logic [COND_W-1:0] {
    SEQ_PLAIN  = 2'b00,
    SEQ_READY  = 2'b01,
    SEQ_BRANCH = 2'b10,
    SEQ_MODE   = 2'b11
  } seq_cond_e;

  typedef struct packed {
    logic            dispatch;
    seq_cond_e       cond;
    logic [ST_W-1:0] jump;
    logic [DP_W-1:0] dp;
  } ctrl_word_t;

  // OR the selected condition into its jump-address bit
  function automatic logic [ST_W-1:0] merge_cond(
    input logic [ST_W-1:0] jump,
    input seq_cond_e       cond,
    input logic            ready,
    input logic            ben,
    input logic            mode_bit
  );
    logic [ST_W-1:0] m;
    m = '0;
    case (cond)
      SEQ_READY:  m[1] = ready;
      SEQ_BRANCH: m[2] = ben;
      SEQ_MODE:   m[0] = mode_bit;
      default:    m = '0;
    endcase
    return jump | m;
  endfunction

  // direct opcode dispatch: zero-extend the opcode to a state number
  function automatic logic [ST_W-1:0] dispatch_addr(input logic [OP_W-1:0] op);
    return {{(ST_W-OP_W){1'b0}}, op};
  endfunction

  // branch enable from instruction bits 11..9 and {N,Z,P}
  function automatic logic branch_enable(input logic [2:0] sel, input logic [2:0] nzp);
    return |(sel & nzp);
  endfunction

endpackage

// File: rtl/useq_cstore.sv
module useq_cstore
  import useq_pkg::*;
(
  input  logic [ST_W-1:0] state,
  output ctrl_word_t      word
);

  function automatic ctrl_word_t entry(input int s);
    ctrl_word_t w;
    w = '0;
    w.cond = SEQ_PLAIN;
    w.jump = ST_W'(18);
    case (s)
      18, 19: begin
        w.dp[DP_LD_MAR]  = 1'b1;
        w.dp[DP_GATE_PC] = 1'b1;
        w.dp[DP_LD_PC]   = 1'b1;
        w.jump           = ST_W'(33);
      end
      33: begin
        w.dp[DP_MEM_EN] = 1'b1;
        w.dp[DP_LD_MDR] = 1'b1;
        w.dp[DP_WORD]   = 1'b1;
        w.cond          = SEQ_READY;
        w.jump          = ST_W'(33);
      end
      35: begin
        w.dp[DP_GATE_MDR] = 1'b1;
        w.dp[DP_LD_IR]    = 1'b1;
        w.jump            = ST_W'(32);
      end
      32: begin
        w.dp[DP_LD_BEN] = 1'b1;
        w.dispatch      = 1'b1;
        w.jump          = '0;
      end
      0: begin
        w.cond = SEQ_BRANCH;
        w.jump = ST_W'(18);
      end
      22: begin
        w.dp[DP_LD_PC]                = 1'b1;
        w.dp[DP_PCSEL +: 2]           = 2'd2;
        w.dp[DP_OFFSEL +: 2]          = 2'd2;
        w.dp[DP_SHL1]                 = 1'b1;
      end
      1, 5, 9: begin
        w.dp[DP_LD_REG]      = 1'b1;
        w.dp[DP_LD_CC]       = 1'b1;
        w.dp[DP_GATE_ALU]    = 1'b1;
        w.dp[DP_SR1SEL]      = 1'b1;
        w.dp[DP_ALUOP +: 2]  = (s == 1) ? 2'd0 : (s == 5) ? 2'd1 : 2'd2;
      end
      12: begin
        w.dp[DP_LD_PC]       = 1'b1;
        w.dp[DP_PCSEL +: 2]  = 2'd2;
        w.dp[DP_BASESEL]     = 1'b1;
        w.dp[DP_SR1SEL]      = 1'b1;
      end
      13: begin
        w.dp[DP_GATE_SHF] = 1'b1;
        w.dp[DP_LD_REG]   = 1'b1;
        w.dp[DP_LD_CC]    = 1'b1;
        w.dp[DP_SR1SEL]   = 1'b1;
      end
      14: begin
        w.dp[DP_LD_REG]       = 1'b1;
        w.dp[DP_LD_CC]        = 1'b1;
        w.dp[DP_GATE_ADDR]    = 1'b1;
        w.dp[DP_ADDRSEL]      = 1'b1;
        w.dp[DP_OFFSEL +: 2]  = 2'd2;
        w.dp[DP_SHL1]         = 1'b1;
      end
      4: begin
        w.cond = SEQ_MODE;
        w.jump = ST_W'(20);
      end
      20: begin
        w.dp[DP_LD_REG]      = 1'b1;
        w.dp[DP_DRSEL]       = 1'b1;
        w.dp[DP_GATE_PC]     = 1'b1;
        w.dp[DP_LD_PC]       = 1'b1;
        w.dp[DP_PCSEL +: 2]  = 2'd2;
        w.dp[DP_BASESEL]     = 1'b1;
        w.dp[DP_SR1SEL]      = 1'b1;
      end
      21: begin
        w.dp[DP_LD_REG]       = 1'b1;
        w.dp[DP_DRSEL]        = 1'b1;
        w.dp[DP_GATE_PC]      = 1'b1;
        w.dp[DP_LD_PC]        = 1'b1;
        w.dp[DP_PCSEL +: 2]   = 2'd2;
        w.dp[DP_OFFSEL +: 2]  = 2'd3;
        w.dp[DP_SHL1]         = 1'b1;
      end
      15: begin
        w.dp[DP_LD_MAR]    = 1'b1;
        w.dp[DP_GATE_ADDR] = 1'b1;
        w.jump             = ST_W'(28);
      end
      28: begin
        w.dp[DP_MEM_EN]  = 1'b1;
        w.dp[DP_LD_MDR]  = 1'b1;
        w.dp[DP_WORD]    = 1'b1;
        w.dp[DP_LD_REG]  = 1'b1;
        w.dp[DP_DRSEL]   = 1'b1;
        w.dp[DP_GATE_PC] = 1'b1;
        w.cond           = SEQ_READY;
        w.jump           = ST_W'(28);
      end
      30: begin
        w.dp[DP_GATE_MDR]    = 1'b1;
        w.dp[DP_LD_PC]       = 1'b1;
        w.dp[DP_PCSEL +: 2]  = 2'd1;
      end
      2, 3, 6, 7: begin
        w.dp[DP_LD_MAR]       = 1'b1;
        w.dp[DP_GATE_ADDR]    = 1'b1;
        w.dp[DP_ADDRSEL]      = 1'b1;
        w.dp[DP_BASESEL]      = 1'b1;
        w.dp[DP_SR1SEL]       = 1'b1;
        w.dp[DP_OFFSEL +: 2]  = 2'd1;
        w.dp[DP_SHL1]         = (s == 6) || (s == 7);
        w.jump = (s == 2) ? ST_W'(29) : (s == 3) ? ST_W'(24) :
                 (s == 6) ? ST_W'(25) : ST_W'(23);
      end
      29, 25: begin
        w.dp[DP_MEM_EN] = 1'b1;
        w.dp[DP_LD_MDR] = 1'b1;
        w.dp[DP_WORD]   = (s == 25);
        w.cond          = SEQ_READY;
        w.jump          = ST_W'(s);
      end
      31, 27: begin
        w.dp[DP_GATE_MDR] = 1'b1;
        w.dp[DP_LD_REG]   = 1'b1;
        w.dp[DP_LD_CC]    = 1'b1;
        w.dp[DP_WORD]     = (s == 27);
      end
      24, 23: begin
        w.dp[DP_LD_MDR] = 1'b1;
        w.dp[DP_WORD]   = (s == 23);
        w.jump          = (s == 24) ? ST_W'(17) : ST_W'(16);
      end
      16, 17: begin
        w.dp[DP_MEM_EN] = 1'b1;
        w.dp[DP_WRITE]  = 1'b1;
        w.dp[DP_WORD]   = (s == 16);
        w.cond          = SEQ_READY;
        w.jump          = ST_W'(s);
      end
      default: begin
        // reserved and unused states fall back to fetch
        w.jump = ST_W'(18);
      end
    endcase
    return w;
  endfunction

  ctrl_word_t rom [NUM_STATES];

  for (genvar g = 0; g < NUM_STATES; g++) begin : g_rom
    assign rom[g] = entry(g);
  end

  assign word = rom[state];

endmodule

// File: rtl/useq_addr_gen.sv
module useq_addr_gen
  import useq_pkg::*;
(
  input  ctrl_word_t      word,
  input  logic            mem_ready,
  input  logic            ben,
  input  logic [OP_W-1:0] opcode,
  input  logic            mode_bit,
  output logic [ST_W-1:0] next_state,
  output logic            took_dispatch
);

  logic [ST_W-1:0] cond_addr;

  always_comb begin
    cond_addr     = merge_cond(word.jump, word.cond, mem_ready, ben, mode_bit);
    took_dispatch = word.dispatch;
    next_state    = word.dispatch ? dispatch_addr(opcode) : cond_addr;
  end

endmodule

// File: rtl/useq_ben_unit.sv
module useq_ben_unit
  import useq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [2:0] sel,
  input  logic [2:0] nzp,
  output logic       ben
);

  always_ff @(posedge clk) begin
    if (!rst_n)    ben <= 1'b0;
    else if (load) ben <= branch_enable(sel, nzp);
  end

endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
  import useq_pkg::*;
#(
  parameter logic [ST_W-1:0] RESET_STATE = ST_W'(18)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mem_ready,
  input  logic [6:0]      ir_bits,
  input  logic [2:0]      cc_nzp,
  output logic [ST_W-1:0] state_o,
  output logic [CW_W-1:0] ctrl_o,
  output logic            ben_o
);

  logic [ST_W-1:0] state_q;
  logic [ST_W-1:0] next_state_w;
  logic            dispatch_w;
  logic            ben_w;
  ctrl_word_t      word_w;

  useq_cstore u_cstore (
    .state (state_q),
    .word  (word_w)
  );

  useq_ben_unit u_ben (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (word_w.dp[DP_LD_BEN]),
    .sel   (ir_bits[2:0]),
    .nzp   (cc_nzp),
    .ben   (ben_w)
  );

  useq_addr_gen u_addr (
    .word          (word_w),
    .mem_ready     (mem_ready),
    .ben           (ben_w),
    .opcode        (ir_bits[6:3]),
    .mode_bit      (ir_bits[2]),
    .next_state    (next_state_w),
    .took_dispatch (dispatch_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= RESET_STATE;
    else        state_q <= next_state_w;
  end

  assign state_o = state_q;
  assign ctrl_o  = word_w;
  assign ben_o   = ben_w;

endmodule

// File: rtl/useq_sequencer_chk.sv
module useq_sequencer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mem_ready,
  input logic [6:0] ir_bits,
  input logic [2:0] cc_nzp,
  input logic [5:0] state_o,
  input logic [34:0] ctrl_o,
  input logic       ben_o,
  input logic [5:0] nxt_state,
  input logic       dispatch
);

  AST_FETCH_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 6'd18 || state_o == 6'd19) |=> state_o == 6'd33); // R2

  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 6'd33 && !mem_ready) |=> state_o == 6'd33); // R3

  AST_WAIT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 6'd33 && mem_ready) |=> state_o == 6'd35); // R3

  AST_DECODE_DISPATCH: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == 6'd32 |=> state_o == {2'b00, $past(ir_bits[6:3])}); // R4

  AST_BEN_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == 6'd32 |=> ben_o == |($past(ir_bits[2:0]) & $past(cc_nzp))); // R5

  AST_BRANCH_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == 6'd0 |=> state_o == ($past(ben_o) ? 6'd22 : 6'd18)); // R5

  AST_CALL_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == 6'd4 |=> state_o == ($past(ir_bits[2]) ? 6'd21 : 6'd20)); // R6

  AST_DISPATCH_ONLY_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    (dispatch || ctrl_o[34]) |-> state_o == 6'd32); // R8

  AST_RESERVED_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 6'd10 || state_o == 6'd11) |-> $past(state_o) == 6'd32); // R9

  AST_STATE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> state_o == $past(nxt_state)); // R10

endmodule

bind useq_sequencer useq_sequencer_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_ready (mem_ready),
  .ir_bits   (ir_bits),
  .cc_nzp    (cc_nzp),
  .state_o   (state_o),
  .ctrl_o    (ctrl_o),
  .ben_o     (ben_o),
  .nxt_state (next_state_w),
  .dispatch  (dispatch_w)
);

// File: tb/useq_sequencer_tb.sv
module useq_sequencer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_ready = 1'b0;
  logic [6:0]  ir_bits = '0;
  logic [2:0]  cc_nzp = '0;
  logic [5:0]  state_o;
  logic [34:0] ctrl_o;
  logic        ben_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  useq_sequencer dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_ready (mem_ready),
    .ir_bits   (ir_bits),
    .cc_nzp    (cc_nzp),
    .state_o   (state_o),
    .ctrl_o    (ctrl_o),
    .ben_o     (ben_o)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // behavioural transition model, one case per state meaning
  function automatic int model_next(input int s, input bit r, input bit [6:0] ir, input bit ben);
    case (s)
      18, 19: return 33;
      33:     return r ? 35 : 33;
      35:     return 32;
      32:     return int'(ir[6:3]);
      0:      return ben ? 22 : 18;
      4:      return ir[2] ? 21 : 20;
      15:     return 28;
      28:     return r ? 30 : 28;
      2:      return 29;
      29:     return r ? 31 : 29;
      6:      return 25;
      25:     return r ? 27 : 25;
      3:      return 24;
      24:     return 17;
      17:     return r ? 19 : 17;
      7:      return 23;
      23:     return 16;
      16:     return r ? 18 : 16;
      default: return 18;
    endcase
  endfunction

  function automatic string tag_of(input int s);
    case (s)
      18, 19:                 return "R2";
      33, 35:                 return "R3";
      32:                     return "R4";
      0:                      return "R5";
      4:                      return "R6";
      28, 29, 25, 16, 17:     return "R7";
      10, 11:                 return "R9";
      default:                return "R10";
    endcase
  endfunction

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int  exp_state;
    int  prev_state;
    bit  exp_ben;
    bit  nb;
    int  idx;
    int  cyc;
    bit [7:0] lfsr;
    bit  done;

    lfsr = 8'hA5;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "reset state", int'(state_o), 18);
    check("R1", "reset ben", int'(ben_o), 0);
    check("R1", "reset jump field", int'(ctrl_o[31:26]), 33);
    check("R1", "reset mar load", int'(ctrl_o[25]), 1);

    rst_n = 1'b1;
    exp_state = 18;
    prev_state = 18;
    exp_ben = 1'b0;
    idx = 0;
    cyc = 0;
    done = 1'b0;

    while (!done) begin
      if (cyc > 0) begin
        check(tag_of(prev_state), "state", int'(state_o), exp_state);
        check("R5", "ben", int'(ben_o), int'(exp_ben));
        check("R8", "dispatch bit", int'(ctrl_o[34]), int'(exp_state == 32));
        check("R8", "ben load bit", int'(ctrl_o[22]), int'(exp_state == 32));
        check("R8", "ir load bit", int'(ctrl_o[23]), int'(exp_state == 35));
      end
      // R3 directed: first fetch wait held low for its whole window
      if (cyc == 10) check("R3", "held in fetch wait", int'(state_o), 33);

      if (exp_state == 18 || exp_state == 19) begin
        if (idx == 64) begin
          done = 1'b1;
        end else begin
          ir_bits[6:3] = 4'(idx % 16);
          ir_bits[2:0] = 3'((idx + (idx / 16) * 5) % 8);
          cc_nzp       = 3'b001 << ((idx / 2) % 3);
          idx++;
        end
      end

      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      mem_ready = (cyc < 12) ? 1'b0 : (lfsr[0] | lfsr[1]);

      if (!done) begin
        nb = exp_ben;
        if (exp_state == 32) nb = |(ir_bits[2:0] & cc_nzp);
        prev_state = exp_state;
        exp_state  = model_next(exp_state, mem_ready, ir_bits, exp_ben);
        exp_ben    = nb;
        cyc++;
        @(negedge clk);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule